// File: doc/BRIEF.md
# Serial Write-Enable Latch Controller

This block is the serial command front end that guards programming of an on-chip nonvolatile memory. A host talks to it over a four-wire SPI link in mode 0. While the select line is low, the block takes in one 8-bit opcode, most significant bit first. It keeps a single write-enable latch in an 8-bit status byte, and it lets the host read that byte back. When a program or erase opcode arrives, it sends a one-cycle permit strobe to the memory back end, but only while the latch is set. Address and data phases, the array itself and erase timing belong to the back end.

The SPI pins are brought into the system clock domain through synchronisers of equal depth, and every edge is detected there. The select line, serial clock and serial data therefore keep their relative order. Only the final opcode bit of a frame counts. After it, the block ignores the serial lines until the select line goes high. A read-only build has no status register. In that build the latch stays 0, no permit strobe is raised and the output driver is never enabled. The serial output is given as a data bit plus an enable. The pad drives high impedance whenever the enable is low.

Top module: `spi_wel_ctrl`

## Requirements
- R1: During and straight after reset, wr_enabled is 0, spi_miso_en is 0, and prog_go and erase_go are 0.
- R2: A complete frame carrying opcode 0x06, sent MSB first on rising spi_clk, sets wr_enabled to 1.
- R3: Opcode 0x04 clears wr_enabled. The program opcode 0x02 and the erase opcode 0x20 leave it unchanged.
- R4: Opcode 0x02 raises prog_go, and opcode 0x20 raises erase_go, each for exactly one clk cycle and only when wr_enabled is 1. When wr_enabled is 0, these opcodes produce no strobe.
- R5: Opcode 0x05 sets spi_miso_en for the rest of the frame. The status byte goes out MSB first, and each bit changes after a falling spi_clk. Bit 1 holds wr_enabled and every other bit is 0.
- R6: spi_miso_en stays 0 in every frame whose opcode is not 0x05, including the 0x06 frame.
- R7: After the eighth opcode bit, any further spi_clk edges in the same frame have no effect, whether the opcode was recognised or not.
- R8: A frame that ends before 8 bits changes nothing. The bit count restarts in every new frame.
- R9: If the eighth rising spi_clk and the rise of spi_sel_n reach the synchronised domain in the same clk cycle, the frame is discarded.
- R10: With READ_ONLY set, wr_enabled stays 0, no strobe is raised and spi_miso_en is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk | input | 1 | Serial clock from the host (mode 0) |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, valid while spi_miso_en is 1 |
| spi_miso_en | output | 1 | Output driver enable; the pad is high impedance when 0 |
| wr_enabled | output | 1 | State of the write-enable latch |
| prog_go | output | 1 | One-cycle permit strobe for a program command |
| erase_go | output | 1 | One-cycle permit strobe for an erase command |

## Verification
Two things can land in the same synchronised clk cycle: the completion of an opcode on its eighth rising serial clock, and the frame abort caused by the select line rising. The bench provokes this by sending seven bits of 0x06. It then drives the eighth rising spi_clk and the rise of spi_sel_n on the same clock edge, so that the equal-depth synchronisers deliver both together. The result is judged at the ports: wr_enabled must still read 0 afterwards, and a normal 0x06 frame sent next must then set it, which shows that the bit count restarted.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

  localparam int OP_W   = 8;
  localparam int STAT_W = 8;

  typedef enum logic [2:0] {
    OPC_NONE,
    OPC_SET,
    OPC_CLR,
    OPC_RDST,
    OPC_PROG,
    OPC_ERASE
  } opc_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_STAT,
    PH_HOLD
  } phase_e;

  // Map a received opcode onto its command class.
  function automatic opc_e classify(input logic [OP_W-1:0] op,
                                    input logic [OP_W-1:0] o_set,
                                    input logic [OP_W-1:0] o_clr,
                                    input logic [OP_W-1:0] o_rd,
                                    input logic [OP_W-1:0] o_pr,
                                    input logic [OP_W-1:0] o_er);
    opc_e c;
    c = OPC_NONE;
    if (op == o_set)      c = OPC_SET;
    else if (op == o_clr) c = OPC_CLR;
    else if (op == o_rd)  c = OPC_RDST;
    else if (op == o_pr)  c = OPC_PROG;
    else if (op == o_er)  c = OPC_ERASE;
    return c;
  endfunction

  // Build the status byte: only the latch bit may be non-zero.
  function automatic logic [STAT_W-1:0] make_status(input logic wel, input int pos);
    logic [STAT_W-1:0] s;
    s = '0;
    s[pos] = wel;
    return s;
  endfunction

  // Shift one serial bit into an opcode register, MSB first.
  function automatic logic [OP_W-1:0] shift_in(input logic [OP_W-1:0] cur, input logic b);
    return {cur[OP_W-2:0], b};
  endfunction

endpackage

// File: rtl/spi_wel_sync.sv
module spi_wel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic spi_mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_act,
  output logic mosi_s
);

  // Bit 2: serial clock, bit 1: select (active low), bit 0: data.
  localparam logic [2:0] IDLE_PINS = 3'b010;

  logic [2:0] pipe [STAGES];
  logic       sclk_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= IDLE_PINS;
          else        pipe[g] <= {spi_clk, spi_sel_n, spi_mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= IDLE_PINS;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= pipe[STAGES-1][2];
  end

  assign sclk_rise = pipe[STAGES-1][2] & ~sclk_d;
  assign sclk_fall = ~pipe[STAGES-1][2] & sclk_d;
  assign sel_act   = ~pipe[STAGES-1][1];
  assign mosi_s    = pipe[STAGES-1][0];

endmodule

// File: rtl/spi_wel_rx.sv
module spi_wel_rx
  import spi_wel_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RDST = 8'h05,
  parameter bit              STAT_OK = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_act,
  input  logic            sclk_rise,
  input  logic            mosi_s,
  output logic            cmd_done,
  output logic [OP_W-1:0] opcode,
  output phase_e          phase
);

  localparam int               CNT_W = $clog2(OP_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OP_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [OP_W-1:0]  sr;
  logic             to_stat;

  assign opcode   = shift_in(sr, mosi_s);
  assign cmd_done = sel_act && (phase == PH_CMD) && sclk_rise && (cnt == LAST);
  assign to_stat  = STAT_OK && (opcode == OP_RDST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sr    <= '0;
      phase <= PH_CMD;
    end else if (!sel_act) begin
      cnt   <= '0;
      sr    <= '0;
      phase <= PH_CMD;
    end else if (phase == PH_CMD && sclk_rise) begin
      sr <= opcode;
      if (cnt == LAST) begin
        cnt   <= '0;
        phase <= to_stat ? PH_STAT : PH_HOLD;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_wel_status.sv
module spi_wel_status
  import spi_wel_pkg::*;
#(
  parameter bit READ_ONLY = 1'b0,
  parameter int WEL_POS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ev,
  input  logic              clr_ev,
  output logic              wel,
  output logic [STAT_W-1:0] status
);

  generate
    if (READ_ONLY) begin : g_absent
      assign wel = 1'b0;
    end else begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wel <= 1'b0;
        else if (clr_ev) wel <= 1'b0;
        else if (set_ev) wel <= 1'b1;
      end
    end
  endgenerate

  assign status = make_status(wel, WEL_POS);

endmodule

// File: rtl/spi_wel_tx.sv
module spi_wel_tx
  import spi_wel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAT_W-1:0] status,
  input  logic              active,
  input  logic              sclk_fall,
  output logic              miso_dat
);

  logic [STAT_W-1:0] tx_sr;

  // Snapshot taken at the last opcode bit; it rotates so that a long read repeats the byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      miso_dat <= 1'b0;
    end else if (load) begin
      tx_sr <= status;
    end else if (active && sclk_fall) begin
      miso_dat <= tx_sr[STAT_W-1];
      tx_sr    <= {tx_sr[STAT_W-2:0], tx_sr[STAT_W-1]};
    end
  end

endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
  import spi_wel_pkg::*;
#(
  parameter bit              READ_ONLY   = 1'b0,
  parameter int              SYNC_STAGES = 2,
  parameter logic [OP_W-1:0] OP_SET      = 8'h06,
  parameter logic [OP_W-1:0] OP_CLR      = 8'h04,
  parameter logic [OP_W-1:0] OP_RDST     = 8'h05,
  parameter logic [OP_W-1:0] OP_PROG     = 8'h02,
  parameter logic [OP_W-1:0] OP_ERASE    = 8'h20,
  parameter int              WEL_POS     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_en,
  output logic wr_enabled,
  output logic prog_go,
  output logic erase_go
);

  logic              sclk_rise, sclk_fall, sel_act, mosi_s;
  logic              cmd_done;
  logic [OP_W-1:0]   opcode;
  phase_e            phase;
  opc_e              opc;
  logic              ev_set, ev_clr, ev_rdst, ev_prog, ev_erase;
  logic              wel;
  logic [STAT_W-1:0] status;

  spi_wel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_clk   (spi_clk),
    .spi_sel_n (spi_sel_n),
    .spi_mosi  (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sel_act   (sel_act),
    .mosi_s    (mosi_s)
  );

  spi_wel_rx #(.OP_RDST(OP_RDST), .STAT_OK(!READ_ONLY)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_act   (sel_act),
    .sclk_rise (sclk_rise),
    .mosi_s    (mosi_s),
    .cmd_done  (cmd_done),
    .opcode    (opcode),
    .phase     (phase)
  );

  // Named command events, one per decoded class.
  assign opc      = classify(opcode, OP_SET, OP_CLR, OP_RDST, OP_PROG, OP_ERASE);
  assign ev_set   = cmd_done && (opc == OPC_SET);
  assign ev_clr   = cmd_done && (opc == OPC_CLR);
  assign ev_rdst  = cmd_done && (opc == OPC_RDST) && !READ_ONLY;
  assign ev_prog  = cmd_done && (opc == OPC_PROG);
  assign ev_erase = cmd_done && (opc == OPC_ERASE);

  spi_wel_status #(.READ_ONLY(READ_ONLY), .WEL_POS(WEL_POS)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (ev_set),
    .clr_ev (ev_clr),
    .wel    (wel),
    .status (status)
  );

  spi_wel_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_rdst),
    .status    (status),
    .active    (phase == PH_STAT),
    .sclk_fall (sclk_fall),
    .miso_dat  (spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
    end else begin
      prog_go  <= ev_prog && wel;
      erase_go <= ev_erase && wel;
    end
  end

  assign spi_miso_en = (phase == PH_STAT);
  assign wr_enabled  = wel;

endmodule

// File: rtl/spi_wel_chk.sv
module spi_wel_chk #(
  parameter bit READ_ONLY = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic wel,
  input logic miso_en,
  input logic prog_go,
  input logic erase_go,
  input logic ev_set,
  input logic ev_clr,
  input logic ev_rdst,
  input logic cmd_done,
  input logic sel_act
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (!sel_act) armed <= 1'b0;
    else if (cmd_done) armed <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n)
      assert_reset_state_R1: assert (!wel && !miso_en && !prog_go && !erase_go);
  end

  assert_wel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(ev_set));

  assert_wel_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(ev_clr));

  assert_go_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |-> wel);

  assert_go_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go}));

  assert_prog_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !prog_go);

  assert_erase_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);

  assert_oe_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_en) |-> $past(ev_rdst));

  assert_oe_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miso_en |-> $past(sel_act));

  assert_one_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !armed);

  assert_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    READ_ONLY |-> (!wel && !miso_en && !prog_go && !erase_go));

endmodule

bind spi_wel_ctrl spi_wel_chk #(.READ_ONLY(READ_ONLY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wel      (wr_enabled),
  .miso_en  (spi_miso_en),
  .prog_go  (prog_go),
  .erase_go (erase_go),
  .ev_set   (ev_set),
  .ev_clr   (ev_clr),
  .ev_rdst  (ev_rdst),
  .cmd_done (cmd_done),
  .sel_act  (sel_act)
);

// File: tb/sim_spi_wel_ctrl.sv
`timescale 1ns/1ps
module sim_spi_wel_ctrl;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_clk = 1'b0;
  logic spi_sel_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic miso, miso_en, wel, pgo, ego;
  logic ro_miso, ro_en, ro_wel, ro_pgo, ro_ego;

  int tests = 0;
  int fails = 0;
  int prog_cnt = 0, erase_cnt = 0, ro_go_cnt = 0;
  bit en_seen = 0, ro_en_seen = 0, ro_wel_seen = 0, long_go = 0;
  bit pgo_d = 0, ego_d = 0;

  always #2.5 clk = ~clk;

  spi_wel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .spi_miso(miso), .spi_miso_en(miso_en),
    .wr_enabled(wel), .prog_go(pgo), .erase_go(ego)
  );

  spi_wel_ctrl #(.READ_ONLY(1'b1)) u_ro (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_mosi(spi_mosi), .spi_miso(ro_miso), .spi_miso_en(ro_en),
    .wr_enabled(ro_wel), .prog_go(ro_pgo), .erase_go(ro_ego)
  );

  // Monitor: sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pgo) prog_cnt++;
      if (ego) erase_cnt++;
      if ((pgo && pgo_d) || (ego && ego_d)) long_go = 1;
      pgo_d = pgo;
      ego_d = ego;
      if (miso_en) en_seen = 1;
      if (ro_en) ro_en_seen = 1;
      if (ro_wel) ro_wel_seen = 1;
      if (ro_pgo || ro_ego) ro_go_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_low();
    spi_sel_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    wait_clk(HALF);
    spi_sel_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic send_bit(input logic b);
    spi_mosi = b;
    wait_clk(HALF);
    spi_clk = 1'b1;
    wait_clk(HALF);
    spi_clk = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic frame(input logic [7:0] op);
    sel_low();
    send_bits(op, 8);
    sel_high();
  endtask

  task automatic read_status(output logic [7:0] rx, output bit en_ok);
    rx = '0;
    en_ok = 1;
    sel_low();
    send_bits(8'h05, 8);
    for (int i = 0; i < 8; i++) begin
      spi_mosi = 1'b0;
      wait_clk(HALF);
      rx = {rx[6:0], miso};
      if (!miso_en) en_ok = 0;
      spi_clk = 1'b1;
      wait_clk(HALF);
      spi_clk = 1'b0;
    end
    sel_high();
  endtask

  task automatic t_reset();
    check(!wel, "R1 wel after reset", wel, 0);
    check(!miso_en && !pgo && !ego, "R1 outputs after reset", {miso_en, pgo, ego}, 0);
  endtask

  task automatic t_set();
    en_seen = 0;
    frame(8'h06);
    check(wel, "R2 0x06 sets latch", wel, 1);
    check(!en_seen, "R6 no drive during 0x06 frame", en_seen, 0);
  endtask

  task automatic t_read(input logic [7:0] exp);
    logic [7:0] rx;
    bit ok;
    en_seen = 0;
    read_status(rx, ok);
    check(rx == exp, "R5 status byte", rx, exp);
    check(ok, "R5 drive enabled during read", ok, 1);
    check(!miso_en, "R6 drive released after frame", miso_en, 0);
  endtask

  task automatic t_gate_on();
    int p0 = prog_cnt, e0 = erase_cnt;
    frame(8'h02);
    check(prog_cnt == p0 + 1, "R4 program strobe when enabled", prog_cnt - p0, 1);
    check(wel, "R3 program keeps latch", wel, 1);
    frame(8'h20);
    check(erase_cnt == e0 + 1, "R4 erase strobe when enabled", erase_cnt - e0, 1);
    check(wel, "R3 erase keeps latch", wel, 1);
    check(!long_go, "R4 strobe one cycle", long_go, 0);
  endtask

  task automatic t_clear();
    frame(8'h04);
    check(!wel, "R3 0x04 clears latch", wel, 0);
  endtask

  task automatic t_gate_off();
    int p0 = prog_cnt, e0 = erase_cnt;
    frame(8'h02);
    frame(8'h20);
    check(prog_cnt == p0 && erase_cnt == e0, "R4 no strobe when disabled",
          prog_cnt + erase_cnt - p0 - e0, 0);
  endtask

  task automatic t_ignore();
    // 0x06 then a whole 0x04 in the same frame: tail ignored.
    sel_low();
    send_bits(8'h06, 8);
    send_bits(8'h04, 8);
    sel_high();
    check(wel, "R7 bits after 0x06 ignored", wel, 1);
    frame(8'h04);
    // Unrecognised opcode then 0x06 in the same frame: tail ignored.
    en_seen = 0;
    sel_low();
    send_bits(8'hA5, 8);
    send_bits(8'h06, 8);
    sel_high();
    check(!wel, "R7 bits after unknown opcode ignored", wel, 0);
    check(!en_seen, "R6 no drive for unknown opcode", en_seen, 0);
  endtask

  task automatic t_short();
    frame(8'h06);
    sel_low();
    send_bits(8'h04, 7);
    sel_high();
    check(wel, "R8 short 0x04 frame discarded", wel, 1);
    frame(8'h04);
    check(!wel, "R8 count restarts next frame", wel, 0);
  endtask

  task automatic t_race();
    sel_low();
    send_bits(8'h06, 7);
    spi_mosi = 1'b0;
    wait_clk(HALF);
    spi_clk = 1'b1;
    spi_sel_n = 1'b1;
    wait_clk(HALF);
    spi_clk = 1'b0;
    wait_clk(12);
    check(!wel, "R9 deselect with eighth edge discards", wel, 0);
    frame(8'h06);
    check(wel, "R9 next frame completes normally", wel, 1);
    frame(8'h04);
  endtask

  task automatic t_read_only();
    check(!ro_wel_seen, "R10 read-only latch stays 0", ro_wel_seen, 0);
    check(!ro_en_seen, "R10 read-only never drives", ro_en_seen, 0);
    check(ro_go_cnt == 0, "R10 read-only never strobes", ro_go_cnt, 0);
  endtask

  initial begin
    wait_clk(6);
    check(!wel && !miso_en && !pgo && !ego, "R1 state during reset", {wel, miso_en, pgo, ego}, 0);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_read(8'h00);
    t_set();
    t_read(8'h02);
    t_gate_on();
    t_clear();
    t_read(8'h00);
    t_gate_off();
    t_ignore();
    t_short();
    t_race();
    t_read_only();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule